// File: doc/BRIEF.md
# Crossbar Tile Allocation Controller

This block hands out compute tiles to weight-matrix layer tasks. The pool holds sixteen tiles of 128 by 128 cells each, arranged as four groups. Inside a group the four tiles form a 2×2 grid. Each request carries an input neuron count, an output neuron count and a task tag. A layer that fits one tile takes one free tile. A layer with too many inputs takes a vertical tile pair inside one group. A layer with too many outputs takes a horizontal tile pair inside one group. A request is refused as oversized or invalid, or as busy when no fitting placement is free.

Tasks stay resident until their tag is released, because a tile's weights must not change while its task computes. Several tasks may hold tiles at once. Releasing a tag frees every tile that tag holds. The current occupancy is visible on `occ_map`.

Each cycle the controller's state register records the outcome of the request presented in the previous cycle. There are four states:

- `ST_IDLE`: no request was presented.
- `ST_GRANT`: a placement was found and committed.
- `ST_REJ_SIZE`: the shape is not supported.
- `ST_REJ_BUSY`: the shape is supported but no placement is free.

The transitions do not depend on the present state:

- With no request, the next state is `ST_IDLE` (arc "quiet").
- An unsupported size goes to `ST_REJ_SIZE` (arc "refuse-size").
- A supported size with no free placement goes to `ST_REJ_BUSY` (arc "refuse-busy").
- Otherwise the next state is `ST_GRANT` (arc "place").

Top module: `xbar_tile_alloc`

## Requirements
- R1: When n and m are both 1..128, the grant uses one tile with shape code 0. The chosen tile is the lowest-numbered free one over all groups, where the global tile number is group*4 + local index. Local indices are 0 and 1 for the top row, 2 and 3 for the bottom row. `rsp_mask` bit k stands for local tile k.
- R2: When n is 129..256 and m is 1..128, the grant is a column pair inside one group with shape code 1. The left column (mask 4'b0101) is tried before the right column (mask 4'b1010).
- R3: When m is 129..256 and n is 1..128, the grant is a row pair inside one group with shape code 2. The top row (mask 4'b0011) is tried before the bottom row (mask 4'b1100).
- R4: A request with n or m equal to 0, with n or m above 256, or with both above 128 gets status 1 (too large/invalid). Such a request leaves `occ_map` unchanged.
- R5: A supported request with no free placement gets status 2 (busy) and leaves `occ_map` unchanged.
- R6: Groups are scanned from 0 upward. A pair request skips any group where neither candidate pair is fully free, even when that group has free tiles.
- R7: A release of a held tag clears every tile of that tag in `occ_map` one cycle after `rel_valid`.
- R8: A release of a tag holding no tile pulses `rel_err` for one cycle, one cycle later, and changes nothing.
- R9: The response (`rsp_valid`, status 0 granted, group, mask, shape) appears in the cycle after `req_valid`. Without a request `rsp_valid` is 0. After reset `occ_map` is 0 and `rsp_valid` and `rel_err` are 0.
- R10: When a release and a request arrive in the same cycle, the request is placed against the occupancy before that release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Allocation request strobe |
| req_n | input | CNT_W | Input neuron count |
| req_m | input | CNT_W | Output neuron count |
| req_tag | input | TAG_W | Task tag for the request |
| rel_valid | input | 1 | Release strobe |
| rel_tag | input | TAG_W | Tag to release |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_status | output | 2 | 0 granted, 1 too large/invalid, 2 busy |
| rsp_group | output | GRP_W | Granted group |
| rsp_mask | output | 4 | Granted tiles inside the group |
| rsp_shape | output | 2 | 0 single, 1 column pair, 2 row pair |
| rel_err | output | 1 | Release named an unheld tag |
| occ_map | output | NUM_TILES | Occupied tiles, bit group*4+local |

## Verification
A sweep crosses twelve neuron counts on an empty pool: 0, 1, 64, 127, 128, 129, 200, 255, 256, 257, 300 and 4095. This separates the single, column and row shapes from the refusals at each bound.

A directed fill of all sixteen tiles shows lowest-tile ordering and busy refusal. A fragmented pool shows the column and row preference and the skipping of groups.

A combined release-and-request cycle shows whether placement sees the occupancy before the release. A long pseudo-random mix of requests and releases, compared against an arithmetic occupancy model, covers interleavings that the directed cases miss.

// File: rtl/xta_pkg.sv
package xta_pkg;

    localparam int TILES_PER_GRP = 4;

    typedef enum logic [1:0] {
        SHP_SINGLE = 2'd0,
        SHP_TALL   = 2'd1,
        SHP_WIDE   = 2'd2
    } shape_e;

    typedef enum logic [1:0] {
        RSP_GRANTED   = 2'd0,
        RSP_TOO_LARGE = 2'd1,
        RSP_BUSY      = 2'd2
    } status_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_GRANT    = 2'd1,
        ST_REJ_SIZE = 2'd2,
        ST_REJ_BUSY = 2'd3
    } state_e;

    // Returns {found, mask} for one 2x2 group given its free bits.
    function automatic logic [4:0] group_pick(input logic [3:0] fr, input shape_e s);
        logic [4:0] r;
        r = '0;
        case (s)
            SHP_SINGLE: begin
                for (int t = 3; t >= 0; t--) begin
                    if (fr[t]) r = {1'b1, 4'(1 << t)};
                end
            end
            SHP_TALL: begin
                if (fr[0] && fr[2])      r = 5'b1_0101;
                else if (fr[1] && fr[3]) r = 5'b1_1010;
            end
            SHP_WIDE: begin
                if (fr[0] && fr[1])      r = 5'b1_0011;
                else if (fr[2] && fr[3]) r = 5'b1_1100;
            end
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/xta_classify.sv
module xta_classify
    import xta_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int TILE_DIM = 128
) (
    input  logic [CNT_W-1:0] n_in,
    input  logic [CNT_W-1:0] m_in,
    output logic             fits,
    output shape_e           shape
);

    localparam logic [CNT_W-1:0] LIM_ONE = CNT_W'(TILE_DIM);
    localparam logic [CNT_W-1:0] LIM_TWO = CNT_W'(2 * TILE_DIM);

    logic n_big, m_big, over, zero;

    always_comb begin
        n_big = n_in > LIM_ONE;
        m_big = m_in > LIM_ONE;
        over  = (n_in > LIM_TWO) || (m_in > LIM_TWO);
        zero  = (n_in == '0) || (m_in == '0);
        fits  = !zero && !over && !(n_big && m_big);
        if (n_big)      shape = SHP_TALL;
        else if (m_big) shape = SHP_WIDE;
        else            shape = SHP_SINGLE;
    end

endmodule

// File: rtl/xta_search.sv
module xta_search
    import xta_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int GRP_W      = 2
) (
    input  logic [NUM_GROUPS*TILES_PER_GRP-1:0] free_map,
    input  shape_e                              shape,
    output logic                                found,
    output logic [GRP_W-1:0]                    grp,
    output logic [TILES_PER_GRP-1:0]            mask
);

    logic [4:0] cand [NUM_GROUPS];

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign cand[g] = group_pick(free_map[g*TILES_PER_GRP +: TILES_PER_GRP], shape);
    end

    // Lowest group index wins: scan downward so the last hit is the lowest.
    always_comb begin
        found = 1'b0;
        grp   = '0;
        mask  = '0;
        for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
            if (cand[g][4]) begin
                found = 1'b1;
                grp   = GRP_W'(g);
                mask  = cand[g][3:0];
            end
        end
    end

endmodule

// File: rtl/xta_tile_table.sv
module xta_tile_table #(
    parameter int NUM_TILES = 16,
    parameter int TAG_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 grant_en,
    input  logic [NUM_TILES-1:0] grant_tiles,
    input  logic [TAG_W-1:0]     grant_tag,
    input  logic                 rel_en,
    input  logic [TAG_W-1:0]     rel_tag,
    output logic [NUM_TILES-1:0] used,
    output logic                 rel_hit
);

    logic             used_q  [NUM_TILES];
    logic [TAG_W-1:0] owner_q [NUM_TILES];
    logic [NUM_TILES-1:0] hit_vec;

    for (genvar t = 0; t < NUM_TILES; t++) begin : g_tile
        assign hit_vec[t] = used_q[t] && (owner_q[t] == rel_tag);
        assign used[t]    = used_q[t];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                used_q[t]  <= 1'b0;
                owner_q[t] <= '0;
            end else if (grant_en && grant_tiles[t]) begin
                used_q[t]  <= 1'b1;
                owner_q[t] <= grant_tag;
            end else if (rel_en && hit_vec[t]) begin
                used_q[t]  <= 1'b0;
            end
        end
    end

    assign rel_hit = |hit_vec;

endmodule

// File: rtl/xbar_tile_alloc.sv
module xbar_tile_alloc
    import xta_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int TILE_DIM   = 128,
    parameter int CNT_W      = 12,
    parameter int TAG_W      = 4,
    localparam int NUM_TILES = NUM_GROUPS * TILES_PER_GRP,
    localparam int GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [CNT_W-1:0]         req_n,
    input  logic [CNT_W-1:0]         req_m,
    input  logic [TAG_W-1:0]         req_tag,
    input  logic                     rel_valid,
    input  logic [TAG_W-1:0]         rel_tag,
    output logic                     rsp_valid,
    output logic [1:0]               rsp_status,
    output logic [GRP_W-1:0]         rsp_group,
    output logic [TILES_PER_GRP-1:0] rsp_mask,
    output logic [1:0]               rsp_shape,
    output logic                     rel_err,
    output logic [NUM_TILES-1:0]     occ_map
);

    state_e                   state_q, state_d;
    logic                     fits, found, rel_hit, grant_en;
    shape_e                   shape, shape_q;
    logic [GRP_W-1:0]         grp, grp_q;
    logic [TILES_PER_GRP-1:0] mask, mask_q;
    logic [NUM_TILES-1:0]     used, grant_tiles;
    logic                     rel_err_q;

    xta_classify #(.CNT_W(CNT_W), .TILE_DIM(TILE_DIM)) u_cls (
        .n_in  (req_n),
        .m_in  (req_m),
        .fits  (fits),
        .shape (shape)
    );

    xta_search #(.NUM_GROUPS(NUM_GROUPS), .GRP_W(GRP_W)) u_srch (
        .free_map (~used),
        .shape    (shape),
        .found    (found),
        .grp      (grp),
        .mask     (mask)
    );

    xta_tile_table #(.NUM_TILES(NUM_TILES), .TAG_W(TAG_W)) u_tbl (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant_en    (grant_en),
        .grant_tiles (grant_tiles),
        .grant_tag   (req_tag),
        .rel_en      (rel_valid),
        .rel_tag     (rel_tag),
        .used        (used),
        .rel_hit     (rel_hit)
    );

    // Next-state decision: outcome of the request seen this cycle.
    always_comb begin
        state_d = ST_IDLE;
        if (req_valid) begin
            if (!fits)       state_d = ST_REJ_SIZE;
            else if (!found) state_d = ST_REJ_BUSY;
            else             state_d = ST_GRANT;
        end
    end

    assign grant_en = (state_d == ST_GRANT);

    always_comb begin
        grant_tiles = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (grp == GRP_W'(g)) grant_tiles[g*TILES_PER_GRP +: TILES_PER_GRP] = mask;
        end
    end

    // State register and held placement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            grp_q     <= '0;
            mask_q    <= '0;
            shape_q   <= SHP_SINGLE;
            rel_err_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            rel_err_q <= rel_valid && !rel_hit;
            if (grant_en) begin
                grp_q   <= grp;
                mask_q  <= mask;
                shape_q <= shape;
            end
        end
    end

    // Output decode from the state register.
    always_comb begin
        rsp_valid  = 1'b0;
        rsp_status = RSP_GRANTED;
        rsp_group  = '0;
        rsp_mask   = '0;
        rsp_shape  = SHP_SINGLE;
        unique case (state_q)
            ST_IDLE: begin
                rsp_valid = 1'b0;
            end
            ST_GRANT: begin
                rsp_valid  = 1'b1;
                rsp_status = RSP_GRANTED;
                rsp_group  = grp_q;
                rsp_mask   = mask_q;
                rsp_shape  = shape_q;
            end
            ST_REJ_SIZE: begin
                rsp_valid  = 1'b1;
                rsp_status = RSP_TOO_LARGE;
            end
            ST_REJ_BUSY: begin
                rsp_valid  = 1'b1;
                rsp_status = RSP_BUSY;
            end
        endcase
    end

    assign rel_err = rel_err_q;
    assign occ_map = used;

endmodule

// File: rtl/xta_checker.sv
module xta_checker #(
    parameter int NUM_GROUPS = 4,
    parameter int GRP_W      = 2,
    parameter int CNT_W      = 12,
    parameter int TILE_DIM   = 128,
    parameter int NUM_TILES  = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic [CNT_W-1:0]     req_n,
    input logic [CNT_W-1:0]     req_m,
    input logic                 rel_valid,
    input logic                 rsp_valid,
    input logic [1:0]           rsp_status,
    input logic [GRP_W-1:0]     rsp_group,
    input logic [3:0]           rsp_mask,
    input logic [1:0]           rsp_shape,
    input logic                 rel_err,
    input logic [NUM_TILES-1:0] occ_map
);

    localparam logic [CNT_W-1:0] LIM_ONE = CNT_W'(TILE_DIM);
    localparam logic [CNT_W-1:0] LIM_TWO = CNT_W'(2 * TILE_DIM);

    logic [NUM_TILES-1:0] exp_tiles;
    logic                 ok;

    always_comb begin
        exp_tiles = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (rsp_group == GRP_W'(g)) exp_tiles[g*4 +: 4] = rsp_mask;
        end
    end

    assign ok = rsp_valid && (rsp_status == 2'd0);

    p_grant_on_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> ((($past(occ_map) & exp_tiles) == '0) && ((occ_map & exp_tiles) == exp_tiles)));

    p_single_one_tile_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && rsp_shape == 2'd0) |-> ($countones(rsp_mask) == 1));

    p_tall_column_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && rsp_shape == 2'd1) |-> (rsp_mask == 4'b0101 || rsp_mask == 4'b1010));

    p_wide_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && rsp_shape == 2'd2) |-> (rsp_mask == 4'b0011 || rsp_mask == 4'b1100));

    p_refuse_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'd1) |->
            ($past(req_n) == '0 || $past(req_m) == '0 || $past(req_n) > LIM_TWO ||
             $past(req_m) > LIM_TWO || ($past(req_n) > LIM_ONE && $past(req_m) > LIM_ONE)));

    p_busy_keeps_map_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'd2 && !$past(rel_valid)) |-> (occ_map == $past(occ_map)));

    p_err_after_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rel_err |-> $past(rel_valid));

    p_rsp_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    p_status_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_status != 2'd3);

endmodule

bind xbar_tile_alloc xta_checker #(
    .NUM_GROUPS (NUM_GROUPS),
    .GRP_W      (GRP_W),
    .CNT_W      (CNT_W),
    .TILE_DIM   (TILE_DIM),
    .NUM_TILES  (NUM_TILES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_n      (req_n),
    .req_m      (req_m),
    .rel_valid  (rel_valid),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status),
    .rsp_group  (rsp_group),
    .rsp_mask   (rsp_mask),
    .rsp_shape  (rsp_shape),
    .rel_err    (rel_err),
    .occ_map    (occ_map)
);

// File: tb/sim_xbar_tile_alloc.sv
`timescale 1ns/1ps
module sim_xbar_tile_alloc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [11:0] req_n = '0;
    logic [11:0] req_m = '0;
    logic [3:0]  req_tag = '0;
    logic        rel_valid = 1'b0;
    logic [3:0]  rel_tag = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [1:0]  rsp_group;
    logic [3:0]  rsp_mask;
    logic [1:0]  rsp_shape;
    logic        rel_err;
    logic [15:0] occ_map;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit       m_used [16];
    bit [3:0] m_own  [16];
    bit [31:0] lfsr = 32'h1234_5678;

    always #2 clk = ~clk;

    xbar_tile_alloc u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_n(req_n), .req_m(req_m),
        .req_tag(req_tag), .rel_valid(rel_valid), .rel_tag(rel_tag), .rsp_valid(rsp_valid),
        .rsp_status(rsp_status), .rsp_group(rsp_group), .rsp_mask(rsp_mask),
        .rsp_shape(rsp_shape), .rel_err(rel_err), .occ_map(occ_map)
    );

    task automatic chk(input bit cond, input string req, input string what, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit held(input bit [3:0] tag);
        for (int t = 0; t < 16; t++) if (m_used[t] && m_own[t] == tag) return 1;
        return 0;
    endfunction

    function automatic int model_map();
        int v = 0;
        for (int t = 0; t < 16; t++) if (m_used[t]) v |= (1 << t);
        return v;
    endfunction

    function automatic int nxt();
        lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
        return int'(lfsr & 32'h7fff_ffff);
    endfunction

    // One cycle of stimulus: optional release and optional request together.
    task automatic op(input bit rv, input bit [3:0] rt, input bit qv, input int n, input int m, input bit [3:0] qt);
        int e_stat = 0, e_grp = 0, e_mask = 0, e_shape = 0;
        bit e_err;
        string rq = "R9";
        e_err = rv && !held(rt);
        if (qv) begin
            bit bad = (n == 0) || (m == 0) || (n > 256) || (m > 256) || (n > 128 && m > 128);
            if (bad) begin
                e_stat = 1; rq = "R4";
            end else begin
                bit hit = 0;
                if (n > 128) begin e_shape = 1; rq = "R2"; end
                else if (m > 128) begin e_shape = 2; rq = "R3"; end
                else rq = "R1";
                if (e_shape == 0) begin
                    for (int i = 0; i < 16 && !hit; i++)
                        if (!m_used[i]) begin hit = 1; e_grp = i / 4; e_mask = 1 << (i % 4); end
                end else begin
                    for (int g = 0; g < 4 && !hit; g++) begin
                        int a0 = (e_shape == 1) ? 0 : 0, a1 = (e_shape == 1) ? 2 : 1;
                        int b0 = (e_shape == 1) ? 1 : 2, b1 = 3;
                        if (!m_used[g*4+a0] && !m_used[g*4+a1]) begin
                            hit = 1; e_grp = g; e_mask = (1 << a0) | (1 << a1);
                        end else if (!m_used[g*4+b0] && !m_used[g*4+b1]) begin
                            hit = 1; e_grp = g; e_mask = (1 << b0) | (1 << b1);
                        end
                    end
                end
                if (!hit) begin e_stat = 2; rq = "R5"; end
            end
        end
        @(negedge clk);
        rel_valid = rv; rel_tag = rt;
        req_valid = qv; req_n = 12'(n); req_m = 12'(m); req_tag = qt;
        @(negedge clk);
        rel_valid = 0; req_valid = 0;
        // model update: release first, then grant (grant used pre-release view, R10)
        if (rv) for (int t = 0; t < 16; t++) if (m_used[t] && m_own[t] == rt) m_used[t] = 0;
        if (qv && e_stat == 0)
            for (int k = 0; k < 4; k++) if (e_mask[k]) begin m_used[e_grp*4+k] = 1; m_own[e_grp*4+k] = qt; end
        chk(rsp_valid == qv, "R9", "rsp_valid", int'(rsp_valid), int'(qv));
        if (qv) begin
            chk(rsp_status == 2'(e_stat), rq, "status", int'(rsp_status), e_stat);
            if (e_stat == 0) begin
                chk(rsp_group == 2'(e_grp), rq, "group", int'(rsp_group), e_grp);
                chk(rsp_mask == 4'(e_mask), rq, "mask", int'(rsp_mask), e_mask);
                chk(rsp_shape == 2'(e_shape), rq, "shape", int'(rsp_shape), e_shape);
            end
        end
        chk(rel_err == e_err, "R8", "rel_err", int'(rel_err), int'(e_err));
        chk(int'(occ_map) == model_map(), rv ? "R7" : rq, "occ_map", int'(occ_map), model_map());
    endtask

    task automatic rel_all();
        for (int t = 0; t < 16; t++) if (held(4'(t))) op(1, 4'(t), 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int vals [12] = '{0, 1, 64, 127, 128, 129, 200, 255, 256, 257, 300, 4095};
        for (int t = 0; t < 16; t++) begin m_used[t] = 0; m_own[t] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9: reset state
        chk(rsp_valid == 0, "R9", "reset rsp_valid", int'(rsp_valid), 0);
        chk(occ_map == 0, "R9", "reset occ_map", int'(occ_map), 0);
        chk(rel_err == 0, "R9", "reset rel_err", int'(rel_err), 0);

        // R1 R2 R3 R4: shape sweep on empty pool
        foreach (vals[i]) foreach (vals[j]) begin
            op(0, 0, 1, vals[i], vals[j], 4'd1);
            if (held(4'd1)) op(1, 4'd1, 0, 0, 0, 0);
        end

        // R1 R5: fill with singles, then busy for every supported shape
        for (int t = 0; t < 16; t++) op(0, 0, 1, 5, 7, 4'(t));
        op(0, 0, 1, 100, 100, 4'd0);
        op(0, 0, 1, 200, 10, 4'd0);
        op(0, 0, 1, 10, 200, 4'd0);
        // R7 then R10: release tag 0 together with a request
        op(1, 4'd15, 0, 0, 0, 0);
        op(1, 4'd0, 1, 1, 1, 4'd15);
        // R8: unknown tag
        op(1, 4'd0, 0, 0, 0, 0);
        rel_all();

        // R6: fragmented pool, column and row preference
        op(0, 0, 1, 1, 1, 4'd0);
        op(0, 0, 1, 256, 1, 4'd1);
        op(0, 0, 1, 129, 128, 4'd2);
        op(0, 0, 1, 128, 129, 4'd3);
        op(0, 0, 1, 1, 256, 4'd4);
        op(1, 4'd2, 1, 1, 1, 4'd5);
        rel_all();

        // Pseudo-random mix against the model
        for (int k = 0; k < 3000; k++) begin
            int r = nxt();
            int ft = -1;
            for (int t = 0; t < 16 && ft < 0; t++) if (!held(4'(t))) ft = t;
            if ((r % 3 == 0) || ft < 0)
                op(1, 4'(nxt() % 16), (ft >= 0) && (r % 6 == 0), vals[nxt() % 12], vals[nxt() % 12], 4'(ft < 0 ? 0 : ft));
            else
                op(0, 0, 1, vals[nxt() % 12], vals[nxt() % 12], 4'(ft));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule